// File: doc/BRIEF.md
# Counter Write-Through Flush Sequencer

This block sits between the processor-side flush path and the persistent write queue of an encrypting memory controller. Each flush request brings a line index and its plaintext. The sequencer reads that line's encryption counter from an on-chip counter store and increments it. It sends the line index, the new counter and the plaintext to an external counter-mode encryption stage.

While the encryption stage is busy, the sequencer writes the counter line into the write queue. The counter line is the packed group of counters that holds the updated value. When the ciphertext returns, the sequencer pushes the data line. In the following cycle it acknowledges the flush.

Once an entry sits in the write queue it is durable. The updated counter is therefore always persisted ahead of the data it protects, and software needs no extra flush or barrier for it. Only one flush is in flight at a time. A flush is held off until the queue can take both of its entries.

Top module: `ctr_wt_flush_seq`

## Requirements
- R1: After reset all counters read zero. No push, pad request or acknowledgement is active. `fl_ready` is high whenever `wq_free` is at least 2.
- R2: Every accepted flush produces exactly two queue pushes, in separate cycles. The counter line comes first, with `wq_is_data` = 0. The data line comes second, with `wq_is_data` = 1.
- R3: One cycle after acceptance, `enc_req_valid` pulses for a single cycle. The pulse carries the line index, the plaintext and the line's counter plus one, taken modulo 2^CTR_W.
- R4: The counter line is pushed two cycles after acceptance. Its address is the line index shifted right by GRP_LOG. Its payload packs the 2^GRP_LOG counters of that group, with slot i at bits [i*CTR_W +: CTR_W] holding the counter of line (group << GRP_LOG) + i. The flushed line's slot already holds its incremented value.
- R5: The data line carries the returned ciphertext at address equal to the line index. It is pushed in the first cycle that is at least three cycles after acceptance and in which the ciphertext is available. With a response L cycles after the pad request, that is cycle max(3, 1+L).
- R6: `ack_valid` pulses for one cycle, in the cycle right after the data push, with `ack_addr` equal to the flushed line index.
- R7: While `wq_free` is below 2, `fl_ready` stays low. No request is accepted, no entry is pushed and no counter changes.
- R8: `fl_ready` is low from the cycle after acceptance through the acknowledgement cycle. It returns in the next cycle if the queue has room.
- R9: A ciphertext that arrives during the counter-push cycle is held, and the data line is then pushed in cycle 3.
- R10: Counters wrap from 2^CTR_W-1 to 0 on the next flush of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_valid | input | 1 | Flush request valid |
| fl_ready | output | 1 | Flush request can be taken |
| fl_addr | input | IDX_W | Line index of the flush |
| fl_data | input | DATA_W | Plaintext line |
| enc_req_valid | output | 1 | Pad/encryption request pulse |
| enc_req_addr | output | IDX_W | Line index for pad generation |
| enc_req_ctr | output | CTR_W | Incremented counter for pad generation |
| enc_req_plain | output | DATA_W | Plaintext to be encrypted |
| enc_rsp_valid | input | 1 | Ciphertext valid |
| enc_rsp_cipher | input | DATA_W | Ciphertext |
| wq_free | input | FREE_W | Free entries in the write queue |
| wq_push | output | 1 | Write-queue push |
| wq_is_data | output | 1 | 1 = data line, 0 = counter line |
| wq_addr | output | IDX_W | Entry address (line index or counter group) |
| wq_payload | output | DATA_W | Entry payload |
| ack_valid | output | 1 | Flush acknowledgement pulse |
| ack_addr | output | IDX_W | Line index being acknowledged |

## Verification
Counted from the accepting clock edge, the pad request is due in cycle 1 and the counter push in cycle 2. The data push is due in cycle max(3, 1+L), where L is the encryption stub's latency, and the acknowledgement follows one cycle later. The bench steps one falling edge per cycle from the accepting edge and checks every output in each of those cycles. It expects activity only in the due cycle and silence in all the others. It repeats this for several stub latencies, including the one that lands the ciphertext during the counter push.

// File: rtl/ctr_wt_pkg.sv
package ctr_wt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUMP  = 3'd1,
        ST_CPUSH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_ACK   = 3'd4
    } seq_state_e;

    typedef enum logic {
        WQ_CTR  = 1'b0,
        WQ_DATA = 1'b1
    } wq_kind_e;

    localparam int unsigned PUSHES_PER_FLUSH = 2;

    function automatic logic room_for_pair(input int unsigned free_slots);
        return free_slots >= PUSHES_PER_FLUSH;
    endfunction

endpackage

// File: rtl/ctr_store.sv
module ctr_store
    import ctr_wt_pkg::*;
#(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned CTR_W   = 8,
    parameter int unsigned GRP_LOG = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               line_idx,
    input  logic                           bump_en,
    output logic [CTR_W-1:0]               line_ctr,
    output logic [(CTR_W<<GRP_LOG)-1:0]    grp_line
);
    localparam int unsigned LINES  = 1 << IDX_W;
    localparam int unsigned GRP_N  = 1 << GRP_LOG;
    localparam int unsigned GIDX_W = IDX_W - GRP_LOG;

    logic [CTR_W-1:0]  ctr_mem [LINES];
    logic [GIDX_W-1:0] grp_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                ctr_mem[i] <= '0;
            end
        end else if (bump_en) begin
            ctr_mem[line_idx] <= ctr_mem[line_idx] + 1'b1;
        end
    end

    assign line_ctr = ctr_mem[line_idx];
    assign grp_idx  = line_idx[IDX_W-1:GRP_LOG];

    for (genvar s = 0; s < GRP_N; s++) begin : g_slot
        assign grp_line[s*CTR_W +: CTR_W] = ctr_mem[{grp_idx, GRP_LOG'(s)}];
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import ctr_wt_pkg::*;
#(
    parameter int unsigned FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_valid,
    input  logic [FREE_W-1:0] wq_free,
    input  logic              cipher_avail,
    output logic              fl_ready,
    output logic              take,
    output logic              bump_en,
    output logic              enc_req_valid,
    output logic              push_ctr,
    output logic              push_data,
    output logic              ack_pulse
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d          = st_q;
        fl_ready      = 1'b0;
        take          = 1'b0;
        bump_en       = 1'b0;
        enc_req_valid = 1'b0;
        push_ctr      = 1'b0;
        push_data     = 1'b0;
        ack_pulse     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                fl_ready = room_for_pair(32'(wq_free));
                take     = fl_valid && fl_ready;
                if (take) st_d = ST_BUMP;
            end
            ST_BUMP: begin
                bump_en       = 1'b1;
                enc_req_valid = 1'b1;
                st_d          = ST_CPUSH;
            end
            ST_CPUSH: begin
                push_ctr = 1'b1;
                st_d     = ST_WAIT;
            end
            ST_WAIT: begin
                if (cipher_avail) begin
                    push_data = 1'b1;
                    st_d      = ST_ACK;
                end
            end
            ST_ACK: begin
                ack_pulse = 1'b1;
                st_d      = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Ordering tracker: set when the counter line is in the queue.
    logic ctr_done_q;
    always_ff @(posedge clk) begin
        if (rst)            ctr_done_q <= 1'b0;
        else if (push_ctr)  ctr_done_q <= 1'b1;
        else if (ack_pulse) ctr_done_q <= 1'b0;
    end

    AST_DATA_AFTER_CTR: assert property (@(posedge clk) disable iff (rst)
        push_data |-> ctr_done_q); // R2
    AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |-> $past(push_data)); // R6
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        enc_req_valid |=> !enc_req_valid); // R3

endmodule

// File: rtl/wq_former.sv
module wq_former
    import ctr_wt_pkg::*;
#(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned CTR_W   = 8,
    parameter int unsigned GRP_LOG = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_ctr,
    input  logic                         push_data,
    input  logic [IDX_W-1:0]             line_idx,
    input  logic [(CTR_W<<GRP_LOG)-1:0]  grp_line,
    input  logic                         enc_rsp_valid,
    input  logic [(CTR_W<<GRP_LOG)-1:0]  enc_rsp_cipher,
    output logic                         cipher_avail,
    output logic                         wq_push,
    output logic                         wq_is_data,
    output logic [IDX_W-1:0]             wq_addr,
    output logic [(CTR_W<<GRP_LOG)-1:0]  wq_payload
);
    localparam int unsigned DATA_W = CTR_W << GRP_LOG;

    logic              have_q;
    logic [DATA_W-1:0] cipher_q;
    logic [DATA_W-1:0] cipher_now;
    wq_kind_e          kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q   <= 1'b0;
            cipher_q <= '0;
        end else if (push_data) begin
            have_q   <= 1'b0;
        end else if (enc_rsp_valid) begin
            have_q   <= 1'b1;
            cipher_q <= enc_rsp_cipher;
        end
    end

    assign cipher_avail = have_q || enc_rsp_valid;
    assign cipher_now   = have_q ? cipher_q : enc_rsp_cipher;
    assign kind         = push_data ? WQ_DATA : WQ_CTR;
    assign wq_push      = push_ctr || push_data;
    assign wq_is_data   = (kind == WQ_DATA);
    assign wq_addr      = push_data ? line_idx
                                    : {{GRP_LOG{1'b0}}, line_idx[IDX_W-1:GRP_LOG]};
    assign wq_payload   = push_data ? cipher_now : grp_line;

    AST_PUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(push_ctr && push_data)); // R2
    AST_DATA_HAS_CIPHER: assert property (@(posedge clk) disable iff (rst)
        push_data |-> (have_q || enc_rsp_valid)); // R9

endmodule

// File: rtl/ctr_wt_flush_seq.sv
module ctr_wt_flush_seq
    import ctr_wt_pkg::*;
#(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned CTR_W   = 8,
    parameter int unsigned GRP_LOG = 2,
    parameter int unsigned FREE_W  = 4,
    localparam int unsigned DATA_W = CTR_W << GRP_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_valid,
    output logic              fl_ready,
    input  logic [IDX_W-1:0]  fl_addr,
    input  logic [DATA_W-1:0] fl_data,
    output logic              enc_req_valid,
    output logic [IDX_W-1:0]  enc_req_addr,
    output logic [CTR_W-1:0]  enc_req_ctr,
    output logic [DATA_W-1:0] enc_req_plain,
    input  logic              enc_rsp_valid,
    input  logic [DATA_W-1:0] enc_rsp_cipher,
    input  logic [FREE_W-1:0] wq_free,
    output logic              wq_push,
    output logic              wq_is_data,
    output logic [IDX_W-1:0]  wq_addr,
    output logic [DATA_W-1:0] wq_payload,
    output logic              ack_valid,
    output logic [IDX_W-1:0]  ack_addr
);
    logic              take, bump_en, push_ctr, push_data, cipher_avail;
    logic [IDX_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;
    logic [CTR_W-1:0]  line_ctr;
    logic [DATA_W-1:0] grp_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= fl_addr;
            data_q <= fl_data;
        end
    end

    seq_ctrl #(.FREE_W(FREE_W)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .fl_valid      (fl_valid),
        .wq_free       (wq_free),
        .cipher_avail  (cipher_avail),
        .fl_ready      (fl_ready),
        .take          (take),
        .bump_en       (bump_en),
        .enc_req_valid (enc_req_valid),
        .push_ctr      (push_ctr),
        .push_data     (push_data),
        .ack_pulse     (ack_valid)
    );

    ctr_store #(.IDX_W(IDX_W), .CTR_W(CTR_W), .GRP_LOG(GRP_LOG)) store_i (
        .clk      (clk),
        .rst      (rst),
        .line_idx (addr_q),
        .bump_en  (bump_en),
        .line_ctr (line_ctr),
        .grp_line (grp_line)
    );

    wq_former #(.IDX_W(IDX_W), .CTR_W(CTR_W), .GRP_LOG(GRP_LOG)) former_i (
        .clk            (clk),
        .rst            (rst),
        .push_ctr       (push_ctr),
        .push_data      (push_data),
        .line_idx       (addr_q),
        .grp_line       (grp_line),
        .enc_rsp_valid  (enc_rsp_valid),
        .enc_rsp_cipher (enc_rsp_cipher),
        .cipher_avail   (cipher_avail),
        .wq_push        (wq_push),
        .wq_is_data     (wq_is_data),
        .wq_addr        (wq_addr),
        .wq_payload     (wq_payload)
    );

    assign enc_req_addr  = addr_q;
    assign enc_req_ctr   = line_ctr + 1'b1;
    assign enc_req_plain = data_q;
    assign ack_addr      = addr_q;

    logic [GRP_LOG-1:0] slot_sel;
    logic [CTR_W-1:0]   slot_val;
    assign slot_sel = addr_q[GRP_LOG-1:0];
    assign slot_val = CTR_W'(wq_payload >> (CTR_W * int'(slot_sel)));

    AST_CTR_SLOT_MATCH: assert property (@(posedge clk) disable iff (rst)
        (wq_push && !wq_is_data) |-> (slot_val == $past(enc_req_ctr))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        fl_ready |-> !(wq_push || enc_req_valid || ack_valid)); // R8
    AST_NO_TAKE_WITHOUT_ROOM: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && (wq_free < FREE_W'(2))) |=> !enc_req_valid); // R7

endmodule

// File: tb/ctr_wt_flush_seq_tb_top.sv
module ctr_wt_flush_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W   = 4;
    localparam int CTR_W   = 8;
    localparam int GRP_LOG = 2;
    localparam int FREE_W  = 4;
    localparam int DATA_W  = CTR_W << GRP_LOG;
    localparam int LINES   = 1 << IDX_W;
    localparam int GRP_N   = 1 << GRP_LOG;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fl_valid = 1'b0;
    logic              fl_ready;
    logic [IDX_W-1:0]  fl_addr = '0;
    logic [DATA_W-1:0] fl_data = '0;
    logic              enc_req_valid;
    logic [IDX_W-1:0]  enc_req_addr;
    logic [CTR_W-1:0]  enc_req_ctr;
    logic [DATA_W-1:0] enc_req_plain;
    logic              enc_rsp_valid;
    logic [DATA_W-1:0] enc_rsp_cipher;
    logic [FREE_W-1:0] wq_free = FREE_W'(2);
    logic              wq_push;
    logic              wq_is_data;
    logic [IDX_W-1:0]  wq_addr;
    logic [DATA_W-1:0] wq_payload;
    logic              ack_valid;
    logic [IDX_W-1:0]  ack_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int model_ctr [LINES];
    int stub_lat = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_wt_flush_seq #(.IDX_W(IDX_W), .CTR_W(CTR_W), .GRP_LOG(GRP_LOG), .FREE_W(FREE_W)) dut_i (
        .clk(clk), .rst(rst),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr), .fl_data(fl_data),
        .enc_req_valid(enc_req_valid), .enc_req_addr(enc_req_addr),
        .enc_req_ctr(enc_req_ctr), .enc_req_plain(enc_req_plain),
        .enc_rsp_valid(enc_rsp_valid), .enc_rsp_cipher(enc_rsp_cipher),
        .wq_free(wq_free), .wq_push(wq_push), .wq_is_data(wq_is_data),
        .wq_addr(wq_addr), .wq_payload(wq_payload),
        .ack_valid(ack_valid), .ack_addr(ack_addr)
    );

    function automatic logic [DATA_W-1:0] pad_of(input logic [IDX_W-1:0] a, input logic [CTR_W-1:0] c);
        return {c, (~c) ^ {a, a}, {4'h9, a} + c, 8'h3C ^ c};
    endfunction

    // Encryption stub: answers stub_lat cycles after the request cycle.
    logic              stub_pend = 1'b0;
    int                stub_cnt  = 0;
    logic [DATA_W-1:0] stub_cipher = '0;
    always @(posedge clk) begin
        if (rst) begin
            stub_pend <= 1'b0;
        end else if (enc_req_valid) begin
            stub_pend   <= 1'b1;
            stub_cnt    <= stub_lat - 1;
            stub_cipher <= enc_req_plain ^ pad_of(enc_req_addr, enc_req_ctr);
        end else if (enc_rsp_valid) begin
            stub_pend <= 1'b0;
        end else if (stub_pend) begin
            stub_cnt <= stub_cnt - 1;
        end
    end
    assign enc_rsp_valid  = stub_pend && (stub_cnt == 0);
    assign enc_rsp_cipher = stub_cipher;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_group(input int a);
        logic [DATA_W-1:0] g;
        int base;
        base = (a >> GRP_LOG) << GRP_LOG;
        for (int i = 0; i < GRP_N; i++) begin
            g[i*CTR_W +: CTR_W] = CTR_W'(model_ctr[base + i]);
        end
        return g;
    endfunction

    task automatic do_flush(input int a, input logic [DATA_W-1:0] d);
        int exp_dc;
        @(negedge clk);
        fl_valid = 1'b1;
        fl_addr  = IDX_W'(a);
        fl_data  = d;
        chk("R8", "ready before accept", 64'(fl_ready), 64'(1));
        @(negedge clk);                       // cycle 1
        fl_valid = 1'b0;
        model_ctr[a] = (model_ctr[a] + 1) % (1 << CTR_W);
        chk("R3", "req valid", 64'(enc_req_valid), 64'(1));
        chk("R3", "req addr", 64'(enc_req_addr), 64'(a));
        chk("R3", "req ctr", 64'(enc_req_ctr), 64'(model_ctr[a]));
        chk("R3", "req plain", 64'(enc_req_plain), 64'(d));
        chk("R8", "busy ready c1", 64'(fl_ready), 64'(0));
        chk("R2", "no push c1", 64'(wq_push), 64'(0));
        @(negedge clk);                       // cycle 2
        chk("R2", "ctr push", 64'({wq_push, wq_is_data}), 64'(2'b10));
        chk("R4", "ctr line addr", 64'(wq_addr), 64'(a >> GRP_LOG));
        chk("R4", "ctr line payload", 64'(wq_payload), 64'(exp_group(a)));
        chk("R3", "req one pulse", 64'(enc_req_valid), 64'(0));
        exp_dc = (1 + stub_lat > 3) ? 1 + stub_lat : 3;
        for (int k = 3; k <= exp_dc + 1; k++) begin
            @(negedge clk);
            chk("R8", "busy ready", 64'(fl_ready), 64'(0));
            if (k == exp_dc) begin
                chk("R5", "data push", 64'({wq_push, wq_is_data}), 64'(2'b11));
                chk("R5", "data addr", 64'(wq_addr), 64'(a));
                chk("R5", "data payload", 64'(wq_payload),
                    64'(d ^ pad_of(IDX_W'(a), CTR_W'(model_ctr[a]))));
                chk("R6", "no early ack", 64'(ack_valid), 64'(0));
            end else if (k == exp_dc + 1) begin
                chk("R6", "ack", 64'(ack_valid), 64'(1));
                chk("R6", "ack addr", 64'(ack_addr), 64'(a));
                chk("R2", "no third push", 64'(wq_push), 64'(0));
            end else begin
                chk("R5", "quiet wait", 64'({wq_push, ack_valid}), 64'(0));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) model_ctr[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ready after reset", 64'(fl_ready), 64'(1));
        chk("R1", "outputs quiet", 64'({wq_push, enc_req_valid, ack_valid}), 64'(0));

        // R1: first flush shows a zeroed group except the bumped slot
        do_flush(6, 32'h1234_5678);

        // R7: stall with no room, then with one free entry
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            wq_free  = FREE_W'(f);
            fl_valid = 1'b1;
            fl_addr  = IDX_W'(3);
            fl_data  = 32'hDEAD_BEEF;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk("R7", "stalled ready", 64'(fl_ready), 64'(0));
                chk("R7", "stalled quiet", 64'({wq_push, enc_req_valid, ack_valid}), 64'(0));
            end
            fl_valid = 1'b0;
        end
        wq_free = FREE_W'(2);
        do_flush(3, 32'hCAFE_0003);           // R7: counter of line 3 untouched by stall

        // Sweep all lines over several stub latencies (R9 at latency 1)
        for (int l = 1; l <= 5; l++) begin
            if (l == 4) continue;
            stub_lat = l;
            wq_free  = (l == 5) ? FREE_W'(15) : FREE_W'(2);
            for (int a = 0; a < LINES; a++) begin
                do_flush(a, 32'(a * 32'h0101_0101) ^ 32'(l << 28) ^ 32'h5A5A_A5A5);
            end
        end

        // R10: wrap a counter past its maximum
        stub_lat = 1;
        wq_free  = FREE_W'(2);
        for (int n = 0; n < (1 << CTR_W) + 2; n++) begin
            do_flush(9, 32'(n) ^ 32'h0F0F_0F0F);
        end
        chk("R10", "wrapped counter model", 64'(model_ctr[9]), 64'(6 % (1 << CTR_W)));

        @(negedge clk);
        chk("R8", "ready after last ack", 64'(fl_ready), 64'(1));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule